// File: doc/BRIEF.md
# Bus-Programmed Pulse-Width Modulator

This block produces one pulse-width-modulated output from a free-running cycle counter. Software sets it up through a small word-addressed register bus. The bus has a byte address, a write strobe, 16-bit write data and registered read data. There are four registers:

- a period limit (the counter's terminal value),
- an active-width count,
- a run bit,
- a polarity bit.

Everything runs on a single clock, and the counter advances once per cycle of that clock.

Software may rewrite the period limit and the active width while the output is running. The new values are compared against the live counter from the next cycle on. If a smaller period limit leaves the counter above it, the counter returns to zero on the next clock instead of running on to the top of its range. Polarity can only be changed while the channel is stopped. A polarity write made while the channel runs is dropped.

Top module: `regpwm_top`

## Requirements
- R1: The register bank decodes byte address bits [3:2]: 0x0 holds the period limit, 0x4 the active width, 0x8 the run bit and 0xC the polarity bit. `bus_rdata` presents the register selected by `bus_addr` one clock after the address is applied. The 16-bit registers read back exactly what was written.
- R2: Bit 0 of the run register starts the channel when 1 and stops it when 0. Bits [15:1] of the run and polarity registers read as 0 whatever was written.
- R3: While running, the counter steps 0,1,…,P and then wraps to 0, where P is the period limit, so one period lasts P+1 cycles. The non-inverted output is 1 while the counter is below the active width W. Across any window of P+1 consecutive cycles it is therefore high for exactly W cycles when 0 < W < P.
- R4: When W ≥ P the non-inverted output is 1 for all P+1 cycles of the period. When W = 0 it stays 0.
- R5: Writing 1 to bit 0 of the polarity register inverts the output and writing 0 restores normal polarity. Such a write takes effect only while the channel is stopped; while it runs the write is ignored and the register keeps its value.
- R6: New period-limit and active-width values take effect in the cycle after the write, against the live counter. If the counter is at or above the period limit, it becomes 0 on the next clock.
- R7: While stopped, the counter is held at 0 and `pwm_out` equals the polarity bit. After the run bit is set, the first output cycle reflects counter value 0.
- R8: `pwm_out` is registered. It shows the state computed from the counter of the previous cycle, so a change at the bus reaches the pin two clocks after the write edge.
- R9: Synchronous reset clears all four registers, the counter and `pwm_out` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and counting clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (4) | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one write per asserted cycle |
| bus_wdata | input | DATA_W (16) | Write data |
| bus_rdata | output | DATA_W (16) | Registered read data for the addressed register |
| pwm_out | output | 1 | Modulated output pin |

## Verification
The hardest state to reach is a period limit that shrinks below the live counter while the channel runs. It needs a long period that has advanced far past a later, smaller limit. The bench runs a 201-cycle period with a short active width, waits about 120 cycles so the counter sits well above 20, and then writes a limit of 20. It checks that the output stays low one cycle later and goes high the cycle after, which shows the counter wrapped at once rather than climbing to the top of its range. Ignored polarity writes are confirmed by reading the polarity register back over the bus and by measuring the duty over a full period.

// File: rtl/regpwm_pkg.sv
package regpwm_pkg;
  // Register selector taken from byte address bits [3:2]
  typedef enum logic [1:0] {
    SEL_LIMIT = 2'd0,
    SEL_WIDTH = 2'd1,
    SEL_RUN   = 2'd2,
    SEL_POL   = 2'd3
  } regsel_e;
endpackage

// File: rtl/regpwm_regs.sv
module regpwm_regs
  import regpwm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] limit_q,
  output logic [DATA_W-1:0] width_q,
  output logic              run_q,
  output logic              pol_q,
  output logic [DATA_W-1:0] rdata
);
  regsel_e sel;
  assign sel = regsel_e'(addr[3:2]);

  always_ff @(posedge clk) begin
    if (rst) begin
      limit_q <= '0;
      width_q <= '0;
      run_q   <= 1'b0;
      pol_q   <= 1'b0;
    end else if (we) begin
      case (sel)
        SEL_LIMIT: limit_q <= wdata;
        SEL_WIDTH: width_q <= wdata;
        SEL_RUN:   run_q   <= wdata[0];
        SEL_POL:   if (!run_q) pol_q <= wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (sel)
        SEL_LIMIT: rdata <= limit_q;
        SEL_WIDTH: rdata <= width_q;
        SEL_RUN:   rdata <= {{(DATA_W-1){1'b0}}, run_q};
        SEL_POL:   rdata <= {{(DATA_W-1){1'b0}}, pol_q};
        default:   rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/regpwm_counter.sv
module regpwm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt
);
  logic at_or_past;
  assign at_or_past = (cnt >= limit);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (at_or_past) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/regpwm_outstage.sv
module regpwm_outstage #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             pol,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] limit,
  input  logic [CNT_W-1:0] width,
  output logic             pwm_out
);
  logic width_zero;
  logic full_period;
  logic active;

  assign width_zero  = (width == '0);
  assign full_period = (width >= limit);
  assign active      = !width_zero && (full_period || (cnt < width));

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_out <= 1'b0;
    end else if (run) begin
      pwm_out <= active ^ pol;
    end else begin
      pwm_out <= pol;
    end
  end
endmodule

// File: rtl/regpwm_top.sv
module regpwm_top #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              pwm_out
);
  localparam int CNT_W = DATA_W;

  logic [CNT_W-1:0] limit_q;
  logic [CNT_W-1:0] width_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             pol_q;

  regpwm_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .addr    (bus_addr),
    .we      (bus_we),
    .wdata   (bus_wdata),
    .limit_q (limit_q),
    .width_q (width_q),
    .run_q   (run_q),
    .pol_q   (pol_q),
    .rdata   (bus_rdata)
  );

  regpwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .run   (run_q),
    .limit (limit_q),
    .cnt   (cnt_q)
  );

  regpwm_outstage #(.CNT_W(CNT_W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .run     (run_q),
    .pol     (pol_q),
    .cnt     (cnt_q),
    .limit   (limit_q),
    .width   (width_q),
    .pwm_out (pwm_out)
  );
endmodule

// File: rtl/regpwm_chk.sv
module regpwm_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              pwm_out,
  input logic              run_q,
  input logic              pol_q,
  input logic [DATA_W-1:0] cnt_q,
  input logic [DATA_W-1:0] limit_q,
  input logic [DATA_W-1:0] width_q
);
  // R6: a counter at or past the limit restarts from zero next clock
  assert_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (run_q && cnt_q >= limit_q) |=> (cnt_q == '0));

  // R7: counter pinned at zero while stopped
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!run_q) |=> (cnt_q == '0));

  // R7: stopped output shows the polarity level
  assert_idle_level_R7: assert property (@(posedge clk) disable iff (rst)
    (!run_q) |=> (pwm_out == $past(pol_q)));

  // R5: polarity frozen while running
  assert_pol_locked_R5: assert property (@(posedge clk) disable iff (rst)
    (run_q) |=> $stable(pol_q));

  // R4: zero width never asserts the active level
  assert_zero_width_R4: assert property (@(posedge clk) disable iff (rst)
    (run_q && width_q == '0) |=> (pwm_out == $past(pol_q)));

  // R3: counter never climbs past the limit from within range
  assert_step_R3: assert property (@(posedge clk) disable iff (rst)
    (run_q && cnt_q < limit_q) |=> (cnt_q == $past(cnt_q) + 1'b1) || !run_q);
endmodule

bind regpwm_top regpwm_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .pwm_out (pwm_out),
  .run_q   (run_q),
  .pol_q   (pol_q),
  .cnt_q   (cnt_q),
  .limit_q (limit_q),
  .width_q (width_q)
);

// File: tb/sim_regpwm_top.sv
module sim_regpwm_top;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 4;
  localparam int NVEC = 8;
  localparam int WATCHDOG = 100000;

  localparam logic [ADDR_W-1:0] A_LIMIT = 4'h0;
  localparam logic [ADDR_W-1:0] A_WIDTH = 4'h4;
  localparam logic [ADDR_W-1:0] A_RUN   = 4'h8;
  localparam logic [ADDR_W-1:0] A_POL   = 4'hC;

  // limit, width, polarity, expected high cycles across one full period
  localparam int VT_LIMIT [NVEC] = '{9, 9, 9, 9, 9, 0, 4, 15};
  localparam int VT_WIDTH [NVEC] = '{3, 0, 9, 12, 3, 1, 2, 8};
  localparam int VT_POL   [NVEC] = '{0, 0, 0, 0, 1, 0, 1, 0};
  localparam int VT_HIGH  [NVEC] = '{3, 0, 10, 10, 7, 1, 3, 8};

  logic              clk = 1'b0;
  logic              rst;
  logic [ADDR_W-1:0] bus_addr;
  logic              bus_we;
  logic [DATA_W-1:0] bus_wdata;
  logic [DATA_W-1:0] bus_rdata;
  logic              pwm_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  regpwm_top #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u0 (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pwm_out   (pwm_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input int d);
    bus_addr  = a;
    bus_wdata = d[DATA_W-1:0];
    bus_we    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output int d);
    bus_addr = a;
    bus_we   = 1'b0;
    @(negedge clk);
    d = int'(bus_rdata);
  endtask

  task automatic skip(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic count_high(input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out) h = h + 1;
    end
  endtask

  initial begin
    int v;
    int h;
    rst = 1'b1;
    bus_addr = '0;
    bus_we = 1'b0;
    bus_wdata = '0;
    skip(3);
    rst = 1'b0;
    @(negedge clk);

    // R9 reset state
    chk("R9 out", int'(pwm_out), 0);
    rd(A_LIMIT, v); chk("R9 limit", v, 0);
    rd(A_WIDTH, v); chk("R9 width", v, 0);
    rd(A_RUN, v);   chk("R9 run", v, 0);
    rd(A_POL, v);   chk("R9 pol", v, 0);

    // R1 readback, R2 upper bits
    wr(A_LIMIT, 16'h1234); rd(A_LIMIT, v); chk("R1 limit rb", v, 16'h1234);
    wr(A_WIDTH, 16'hBEEF); rd(A_WIDTH, v); chk("R1 width rb", v, 16'hBEEF);
    wr(A_POL, 16'hFFFE);   rd(A_POL, v);   chk("R2 pol upper", v, 0);
    wr(A_RUN, 16'hFFFF);   rd(A_RUN, v);   chk("R2 run bit", v, 1);
    wr(A_RUN, 0);

    // Vector table: R3 R4 R5
    for (int k = 0; k < NVEC; k++) begin
      wr(A_RUN, 0);
      wr(A_POL, VT_POL[k]);
      wr(A_LIMIT, VT_LIMIT[k]);
      wr(A_WIDTH, VT_WIDTH[k]);
      wr(A_RUN, 1);
      skip(2);
      count_high(VT_LIMIT[k] + 1, h);
      chk($sformatf("R3/R4/R5 vector %0d", k), h, VT_HIGH[k]);
    end

    // R5 polarity write ignored while running
    wr(A_RUN, 0);
    wr(A_POL, 0);
    wr(A_LIMIT, 9);
    wr(A_WIDTH, 3);
    wr(A_RUN, 1);
    wr(A_POL, 1);
    rd(A_POL, v); chk("R5 pol locked rb", v, 0);
    skip(1);
    count_high(10, h); chk("R5 duty unchanged", h, 3);

    // R6 active-width change takes effect while running
    wr(A_WIDTH, 7);
    skip(2);
    count_high(10, h); chk("R6 width live", h, 7);

    // R7 stopped output follows polarity
    wr(A_RUN, 0);
    skip(2);
    chk("R7 idle low", int'(pwm_out), 0);
    wr(A_POL, 1);
    rd(A_POL, v); chk("R5 pol accepted when stopped", v, 1);
    skip(1);
    chk("R7 idle inverted", int'(pwm_out), 1);

    // R7/R8 restart from counter 0: limit 9, width 3, inverted
    wr(A_WIDTH, 3);
    wr(A_RUN, 1);
    @(negedge clk); chk("R8 first cycle cnt0", int'(pwm_out), 0);
    @(negedge clk); chk("R7 cnt1", int'(pwm_out), 0);
    @(negedge clk); chk("R7 cnt2", int'(pwm_out), 0);
    @(negedge clk); chk("R7 cnt3 inactive", int'(pwm_out), 1);

    // R6 limit shrinks below live counter
    wr(A_RUN, 0);
    wr(A_POL, 0);
    wr(A_LIMIT, 200);
    wr(A_WIDTH, 10);
    wr(A_RUN, 1);
    skip(120);
    chk("R3 low past width", int'(pwm_out), 0);
    wr(A_LIMIT, 20);
    @(negedge clk); chk("R6 wrap cycle low", int'(pwm_out), 0);
    @(negedge clk); chk("R6 restart high", int'(pwm_out), 1);
    count_high(21, h); chk("R6 new period duty", h, 10);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule